// File: doc/BRIEF.md
# Render Command Pointer and Flush Controller

This block keeps the bookkeeping for a rendering engine's command queue and its outgoing pixel write FIFO. Software places command packets in a circular memory and moves a write pointer to mark the newest one. The controller holds that pointer and a matching read pointer. The read pointer steps forward by one each time the engine reports that it has consumed a packet. The engine counts as active while it is enabled and the two pointers differ. When it stops being active, for either reason, both pointers return to zero. Software may load the read pointer only while the engine is not active.

The controller also watches the occupancy of a 16-entry pixel FIFO. It raises a memory write request once the occupancy reaches a programmable fraction of the depth. At certain moments it drains the FIFO completely, stalling packet processing until the FIFO is empty:
- A buffer flip always waits for a drain.
- The end of a packet starts a drain only when that option is enabled.

A flip request uses a valid/ready handshake:
- `flip_valid` is raised and held until `flip_ready` is seen high in the same cycle.
- `flip_ready` is high only in the cycle in which the drain finishes.
- The requester must not drop `flip_valid` early.
- The controller applies no other back-pressure.

Top module: `rcmd_flush_ctrl`

## Requirements
- R1: After reset the write pointer and read pointer read 0, the control word reads 0x20 (request level field = 01, all other fields 0), and `stall`, `mem_req`, `flush_done` and `flip_ready` are low.
- R2: The register bus uses word index 0 for the write pointer, 1 for the read pointer and 2 for the control word. Each pointer is 11 bits wide, and a read returns bits 31:11 as zero, so writing 0xFFFFFFFF to the write pointer reads back 0x7FF.
- R3: A `pkt_done` pulse while the engine is active advances the read pointer by one, modulo 2048; a read pointer of 2047 becomes 0.
- R4: In the cycle after the engine leaves the active state, both pointers read 0. The engine leaves the active state when the read pointer reaches the write pointer or when the enable bit is cleared.
- R5: A bus write to the read pointer is ignored while `engine_active` is high. It is taken while `engine_active` is low.
- R6: Control bits 6:5 select the threshold at which `mem_req` is high: 00 means occupancy of at least 4, 01 means at least 8, and 1x means at least 12.
- R7: A flip is granted (`flip_ready` high) only once the FIFO occupancy is 0. `stall` is high from the cycle after `flip_valid` is first seen until the grant.
- R8: Control bit 4 enables the end-of-packet drain. With the bit at 1, a `pkt_end` pulse raises `stall` from the next cycle until the FIFO is empty. With the bit at 0, a `pkt_end` pulse leaves `stall` low.
- R9: If a flip arrives during an end-of-packet drain, that same drain serves it. `flip_ready` and `flush_done` are both high in the cycle the FIFO reaches empty, and `stall` is low in the cycle after.
- R10: `flush_done` is a single-cycle pulse at the end of each drain. While a drain runs and the occupancy is nonzero, `mem_req` is high even below the threshold.
- R11: Control bit 0 drives `eng_enable`, bit 1 drives `front_sel` (1 means front buffer, 0 means back buffer), and bits 3:2 drive `dither_mode` (00 means off, 01 means 2x2, 1x means 4x4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| pkt_done | input | 1 | Engine consumed the current packet |
| pkt_end | input | 1 | Current packet terminated |
| flip_valid | input | 1 | Flip command waiting |
| flip_ready | output | 1 | Flip may proceed (FIFO drained) |
| fifo_level | input | 5 | Pixel FIFO occupancy, 0 to 16 |
| stall | output | 1 | Drain in progress; hold off packet processing |
| flush_done | output | 1 | One-cycle pulse when a drain completes |
| mem_req | output | 1 | Memory write request for the pixel FIFO |
| engine_active | output | 1 | Enabled and pointers differ |
| eng_enable | output | 1 | Engine enable bit |
| front_sel | output | 1 | Render target: 1 front buffer, 0 back buffer |
| dither_mode | output | 2 | Dithering selection |

## Verification
The assertions rely on three assumptions about the inputs:
- `pkt_end` arrives only while `stall` is low.
- `flip_valid` stays high until it is granted.
- `fifo_level` never exceeds 16.

The stimulus keeps to these rules. It pulses `pkt_end` only from the idle state. It holds `flip_valid` until the grant cycle and drops it on the following falling edge. It changes `fifo_level` only on falling edges, within 0 to 16. Pointer loads are issued both while the engine is active and while it is idle, so that the ignore rule and the load rule are each exercised.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  localparam int PTR_W      = 11;
  localparam int FIFO_DEPTH = 16;
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);
  localparam int BUS_W      = 32;

  localparam logic [1:0] ADDR_WPTR = 2'd0;
  localparam logic [1:0] ADDR_RPTR = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  typedef enum logic [1:0] {
    REQ_QUARTER = 2'b00,
    REQ_HALF    = 2'b01,
    REQ_THREEQ  = 2'b10
  } req_sel_e;

  typedef struct packed {
    logic [1:0] req_sel;
    logic       eop_flush;
    logic [1:0] dither;
    logic       front;
    logic       enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic {
    FL_IDLE  = 1'b0,
    FL_DRAIN = 1'b1
  } flush_st_e;
endpackage

// File: rtl/rcf_ctrl_regs.sv
module rcf_ctrl_regs
  import rcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl
);
  localparam ctrl_t CTRL_RST = '{req_sel: 2'b01, default: '0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl <= CTRL_RST;
    else if (wr_en) ctrl <= ctrl_t'(wdata);
  end
endmodule

// File: rtl/rcf_ptrs.sv
module rcf_ptrs
  import rcf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wptr_we,
  input  logic             rptr_we,
  input  logic [PTR_W-1:0] wdata,
  input  logic             pkt_done,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic             active
);
  logic active_q;
  logic went_idle;

  assign active    = enable && (rptr != wptr);
  assign went_idle = active_q && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wptr <= '0;
    else if (went_idle) wptr <= '0;
    else if (wptr_we)   wptr <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rptr <= '0;
    else if (went_idle)           rptr <= '0;
    else if (active && pkt_done)  rptr <= rptr + 1'b1;
    else if (!active && rptr_we)  rptr <= wdata;
  end

  // R3: consumed packet steps the read pointer (wraps)
  a_r3_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pkt_done) |=> (rptr == $past(rptr) + 1'b1));

  // R5: no software load while active
  a_r5_rd_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pkt_done) |=> (rptr == $past(rptr)));

  // R4: both pointers cleared after leaving active
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && !active) |=> (rptr == '0 && wptr == '0));
endmodule

// File: rtl/rcf_flush.sv
module rcf_flush
  import rcf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       req_sel,
  input  logic             eop_flush,
  input  logic             pkt_end,
  input  logic             flip_valid,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             flip_ready,
  output logic             stall,
  output logic             flush_done,
  output logic             mem_req
);
  localparam int TH_Q = FIFO_DEPTH / 4;
  localparam int TH_H = FIFO_DEPTH / 2;
  localparam int TH_T = (3 * FIFO_DEPTH) / 4;

  flush_st_e        st, st_nx;
  logic [LVL_W-1:0] thresh;
  logic             empty;

  assign empty = (fifo_level == '0);

  always_comb begin
    case (req_sel)
      REQ_QUARTER: thresh = LVL_W'(TH_Q);
      REQ_HALF:    thresh = LVL_W'(TH_H);
      default:     thresh = LVL_W'(TH_T);
    endcase
  end

  always_comb begin
    st_nx = st;
    case (st)
      FL_IDLE:  if (flip_valid || (pkt_end && eop_flush)) st_nx = FL_DRAIN;
      FL_DRAIN: if (empty) st_nx = FL_IDLE;
      default:  st_nx = FL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= FL_IDLE;
    else        st <= st_nx;
  end

  assign stall      = (st == FL_DRAIN);
  assign flush_done = stall && empty;
  assign flip_ready = flush_done && flip_valid;
  assign mem_req    = (fifo_level >= thresh) || (stall && !empty);

  // R10: completion pulse lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  // R7: flip granted only with a drained FIFO
  a_r7_flip_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flip_ready |-> (fifo_level == '0));

  // R8: packet end without the enable never stalls
  a_r8_no_eop_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && pkt_end && !eop_flush && !flip_valid) |=> !stall);

  // R9: a pending flip keeps the drain running until granted
  a_r9_flip_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && flip_valid && !flush_done) |=> stall);
endmodule

// File: rtl/rcmd_flush_ctrl.sv
module rcmd_flush_ctrl
  import rcf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             pkt_done,
  input  logic             pkt_end,
  input  logic             flip_valid,
  output logic             flip_ready,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             stall,
  output logic             flush_done,
  output logic             mem_req,
  output logic             engine_active,
  output logic             eng_enable,
  output logic             front_sel,
  output logic [1:0]       dither_mode
);
  ctrl_t            ctrl;
  logic [PTR_W-1:0] wptr, rptr;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[BUS_W-1:PTR_W];

  rcf_ctrl_regs u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr && reg_addr == ADDR_CTRL),
    .wdata (reg_wdata[CTRL_W-1:0]),
    .ctrl  (ctrl)
  );

  rcf_ptrs u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (ctrl.enable),
    .wptr_we  (reg_wr && reg_addr == ADDR_WPTR),
    .rptr_we  (reg_wr && reg_addr == ADDR_RPTR),
    .wdata    (reg_wdata[PTR_W-1:0]),
    .pkt_done (pkt_done),
    .wptr     (wptr),
    .rptr     (rptr),
    .active   (engine_active)
  );

  rcf_flush u_flush (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_sel    (ctrl.req_sel),
    .eop_flush  (ctrl.eop_flush),
    .pkt_end    (pkt_end),
    .flip_valid (flip_valid),
    .fifo_level (fifo_level),
    .flip_ready (flip_ready),
    .stall      (stall),
    .flush_done (flush_done),
    .mem_req    (mem_req)
  );

  always_comb begin
    case (reg_addr)
      ADDR_WPTR: reg_rdata = BUS_W'(wptr);
      ADDR_RPTR: reg_rdata = BUS_W'(rptr);
      ADDR_CTRL: reg_rdata = BUS_W'(ctrl);
      default:   reg_rdata = '0;
    endcase
  end

  assign eng_enable  = ctrl.enable;
  assign front_sel   = ctrl.front;
  assign dither_mode = ctrl.dither;

  // R2: pointer reads never show bits above the pointer width
  a_r2_ptr_width: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != ADDR_CTRL) |-> (reg_rdata[BUS_W-1:PTR_W] == '0));
endmodule

// File: tb/test_rcmd_flush_ctrl.sv
`timescale 1ns/1ps
module test_rcmd_flush_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pkt_done = 1'b0, pkt_end = 1'b0, flip_valid = 1'b0;
  logic        flip_ready, stall, flush_done, mem_req;
  logic        engine_active, eng_enable, front_sel;
  logic [1:0]  dither_mode;
  logic [4:0]  fifo_level = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rcmd_flush_ctrl i_rcmd_flush_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pkt_done(pkt_done),
    .pkt_end(pkt_end), .flip_valid(flip_valid), .flip_ready(flip_ready),
    .fifo_level(fifo_level), .stall(stall), .flush_done(flush_done),
    .mem_req(mem_req), .engine_active(engine_active),
    .eng_enable(eng_enable), .front_sel(front_sel), .dither_mode(dither_mode)
  );

  // {req_sel[1:0], fifo_level[4:0], expected mem_req}
  localparam logic [7:0] REQ_VEC [10] = '{
    {2'b00, 5'd3, 1'b0}, {2'b00, 5'd4, 1'b1}, {2'b01, 5'd7, 1'b0},
    {2'b01, 5'd8, 1'b1}, {2'b01, 5'd16, 1'b1}, {2'b10, 5'd11, 1'b0},
    {2'b10, 5'd12, 1'b1}, {2'b11, 5'd11, 1'b0}, {2'b11, 5'd12, 1'b1},
    {2'b00, 5'd0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk); reg_wr = 1'b0; #1;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); pkt_done = 1'b1;
    @(posedge clk); @(negedge clk); pkt_done = 1'b0; #1;
  endtask

  task automatic pulse_end();
    @(negedge clk); pkt_end = 1'b1;
    @(posedge clk); @(negedge clk); pkt_end = 1'b0; #1;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int dones;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd_reg(2'd0, v); check("R1 wptr", v, 0);
    rd_reg(2'd1, v); check("R1 rptr", v, 0);
    rd_reg(2'd2, v); check("R1 ctrl", v, 32'h20);
    check("R1 outs", {stall, mem_req, flush_done, flip_ready}, 0);

    // R2 pointer width
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_reg(2'd0, v); check("R2 wptr", v, 32'h7FF);
    wr_reg(2'd1, 32'hFFFF_F805);
    rd_reg(2'd1, v); check("R2 rptr", v, 32'h005);

    // R11 control fields
    wr_reg(2'd2, 32'h2E);
    check("R11 front", front_sel, 1);
    check("R11 dither", dither_mode, 3);
    check("R11 enable", eng_enable, 0);

    // R6 threshold table
    for (int i = 0; i < 10; i++) begin
      wr_reg(2'd2, {25'd0, REQ_VEC[i][7:6], 5'd0});
      @(negedge clk); fifo_level = REQ_VEC[i][5:1]; #1;
      check($sformatf("R6 vec%0d", i), mem_req, REQ_VEC[i][0]);
    end
    @(negedge clk); fifo_level = 0;

    // R3/R4/R5 pointer behaviour
    wr_reg(2'd1, 32'd2047);
    wr_reg(2'd0, 32'd1);
    wr_reg(2'd2, 32'h21);
    check("R5 active", engine_active, 1);
    wr_reg(2'd1, 32'd5);
    rd_reg(2'd1, v); check("R5 ignored", v, 2047);
    pulse_done();
    rd_reg(2'd1, v); check("R3 wrap", v, 0);
    pulse_done();
    check("R4 idle", engine_active, 0);
    tick();
    rd_reg(2'd1, v); check("R4 rptr clr", v, 0);
    rd_reg(2'd0, v); check("R4 wptr clr", v, 0);
    wr_reg(2'd1, 32'd9);
    rd_reg(2'd1, v); check("R5 loaded", v, 9);
    wr_reg(2'd2, 32'h20);
    tick();
    rd_reg(2'd1, v); check("R4 disable clr", v, 0);

    // R8 disabled end-of-packet drain
    @(negedge clk); fifo_level = 5;
    pulse_end();
    check("R8 no stall", stall, 0);

    // R8/R10 enabled end-of-packet drain
    wr_reg(2'd2, 32'h30);
    pulse_end();
    check("R8 stall", stall, 1);
    check("R10 req in drain", mem_req, 1);
    tick(); tick();
    check("R8 still stall", stall, 1);
    @(negedge clk); fifo_level = 0; #1;
    check("R10 done", flush_done, 1);
    tick();
    check("R10 done pulse", {flush_done, stall}, 0);

    // R7 flip waits for drain
    @(negedge clk); fifo_level = 3; flip_valid = 1'b1;
    tick();
    check("R7 stall", stall, 1);
    tick(); tick();
    check("R7 no grant", flip_ready, 0);
    @(negedge clk); fifo_level = 0; #1;
    check("R7 grant", {flip_ready, flush_done}, 2'b11);
    @(posedge clk); @(negedge clk); flip_valid = 1'b0; #1;
    check("R7 released", stall, 0);

    // R9 flip joins running drain
    @(negedge clk); fifo_level = 4;
    pulse_end();
    check("R9 drain", stall, 1);
    @(negedge clk); flip_valid = 1'b1;
    tick();
    @(negedge clk); fifo_level = 0; #1;
    check("R9 shared", {flip_ready, flush_done}, 2'b11);
    @(posedge clk); @(negedge clk); flip_valid = 1'b0; #1;
    dones = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      if (flush_done || stall) dones++;
    end
    check("R9 single drain", dones, 0);

    // R7 flip with empty FIFO
    @(negedge clk); flip_valid = 1'b1; #1;
    check("R7 idle no grant", flip_ready, 0);
    @(posedge clk); #1;
    check("R7 empty grant", flip_ready, 1);
    @(negedge clk); flip_valid = 1'b0;

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule